// File: doc/BRIEF.md
# RS485 Serial Transmitter with Fractional Baud Divider

This block turns bytes into asynchronous serial frames on a single line. A producer hands over one byte at a time through a valid/ready handshake. Each frame has a low start bit, 7 or 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The line idles high.

Bit timing comes from a fast reference clock. An integer prescaler sets the length of one oversample slot, and a small phase accumulator adds one extra reference cycle to a slot whenever it overflows, which gives a fractional rate. A bit lasts 10 or 16 such slots.

For half-duplex RS485 drivers the block produces a driver enable. When the line has been quiet, the enable rises one full bit time before the start bit. It stays high through the last stop bit, and it stays high without a fresh lead bit when the next byte is already waiting. An active-low activity output for an LED is low during every frame and is stretched to a minimum length. All frame settings are taken from static inputs at the moment a byte is accepted.

Top module: `uart_tx485`

## Requirements
- R1: After reset and whenever no frame is in progress, txd_o is high, de_o is low, led_no is high and ready_o is high.
- R2: A byte is accepted on a clock edge where valid_i and ready_o are both high. ready_o is high only when idle or in the last cycle of the final stop bit, and it is low in the cycle after an acceptance.
- R3: A frame is a low start bit followed by the data bits, least significant first. len8_i=1 selects 8 data bits. len8_i=0 selects 7 data bits taken from data_i[6:0], and data_i[7] is not sent.
- R4: parity_i encoding: 0 none, 1 odd (the data bits plus parity hold an odd count of ones), 2 even, 3 mark (always 1), 4 space (always 0), and 5 to 7 act as none. When present, the parity bit follows the last data bit.
- R5: two_stop_i=1 sends two high stop bits and two_stop_i=0 sends one.
- R6: One bit lasts OVS oversample slots, with OVS=10 when ovs10_i=1 and OVS=16 otherwise. Each slot lasts div_i or div_i+1 reference cycles, so the frame position stays within one cycle of OVS*(div_i + frac_i/2^FRAC_W) per bit (div_i >= 1).
- R7: When a byte is accepted from idle, de_o rises in the cycle of acceptance. The start bit begins one bit time later, and de_o falls at the end of the final stop bit when no byte follows.
- R8: A byte accepted in the last cycle of a stop bit starts its start bit at once, with no lead bit, and de_o stays high between the two frames.
- R9: led_no is low from the start bit through the last stop bit and stays low for LED_MIN reference cycles after the frame ends.
- R10: Data and all settings (length, stop bits, parity, oversampling, divider, fraction) are captured at acceptance. Changes at the inputs during a frame do not affect that frame.
- R11: With valid_i low, no frame is sent and txd_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte offered |
| data_i | input | 8 | Byte to send |
| ready_o | output | 1 | Byte can be taken this cycle |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| two_stop_i | input | 1 | 1: two stop bits |
| parity_i | input | 3 | Parity mode, encoding in R4 |
| ovs10_i | input | 1 | 1: 10 slots per bit, 0: 16 |
| div_i | input | DIV_W | Integer reference cycles per slot |
| frac_i | input | FRAC_W | Fractional slot extension |
| txd_o | output | 1 | Serial data line |
| de_o | output | 1 | Line driver enable |
| led_no | output | 1 | Activity strobe, active low |

## Verification
Frames are sent with 8-bit and 7-bit lengths. In the 7-bit case bit 7 of the byte is set, which shows whether the top bit is dropped. Each parity mode is paired with a byte whose ones count makes odd and even give opposite bits, so that each mode is distinguished from the others. Integer-only and fractional dividers are used at both oversampling factors, which exposes errors in slot length or slot count through the sampling points at the centre of each bit and the measured lead time. Isolated frames are compared with back-to-back chains, which tells the lead-bit insertion apart from the held enable. The inputs are scrambled after each acceptance to show that the settings were captured.

// File: rtl/uart_tx485_pkg.sv
package uart_tx485_pkg;
  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  function automatic logic par_used(logic [2:0] mode);
    return (mode >= 3'd1) && (mode <= 3'd4);
  endfunction

  function automatic logic par_value(logic [2:0] mode, logic [7:0] d, logic len8);
    logic ones;
    ones = len8 ? ^d : ^d[6:0];
    case (mode)
      PAR_ODD:   return ~ones;
      PAR_EVEN:  return ones;
      PAR_MARK:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx485_baud.sv
module uart_tx485_baud #(
  parameter int DIV_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              ovs10_i,
  output logic              bit_tick_o
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q, acc_q;
  logic              ovs10_q, extra_q;
  logic [CW-1:0]     sub_cnt_q, sub_last;
  logic [3:0]        ovs_cnt_q, ovs_last;
  logic              sub_end;
  logic [FRAC_W:0]   acc_sum;

  // slot length is div, or div+1 when the previous slot overflowed the accumulator
  assign sub_last   = {1'b0, div_q} - CW'(1) + CW'(extra_q);
  assign sub_end    = (sub_cnt_q == sub_last);
  assign ovs_last   = ovs10_q ? 4'd9 : 4'd15;
  assign bit_tick_o = sub_end && (ovs_cnt_q == ovs_last);
  assign acc_sum    = {1'b0, acc_q} + {1'b0, frac_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= DIV_W'(1);
      frac_q    <= '0;
      ovs10_q   <= 1'b0;
      acc_q     <= '0;
      extra_q   <= 1'b0;
      sub_cnt_q <= '0;
      ovs_cnt_q <= '0;
    end else if (load_i) begin
      div_q     <= div_i;
      frac_q    <= frac_i;
      ovs10_q   <= ovs10_i;
      acc_q     <= '0;
      extra_q   <= 1'b0;
      sub_cnt_q <= '0;
      ovs_cnt_q <= '0;
    end else if (sub_end) begin
      sub_cnt_q <= '0;
      {extra_q, acc_q} <= acc_sum;
      ovs_cnt_q <= bit_tick_o ? 4'd0 : ovs_cnt_q + 4'd1;
    end else begin
      sub_cnt_q <= sub_cnt_q + CW'(1);
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != '0) |-> (sub_cnt_q <= sub_last)); // R6
  AST_OVS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovs_cnt_q <= 4'd15 && (!ovs10_q || ovs_cnt_q <= 4'd9)); // R6
endmodule

// File: rtl/uart_tx485_frame.sv
module uart_tx485_frame
  import uart_tx485_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic       len8_i,
  input  logic       two_stop_i,
  input  logic [2:0] parity_i,
  input  logic       bit_tick_i,
  output logic       ready_o,
  output logic       load_o,
  output logic       txd_o,
  output logic       de_o,
  output logic       active_o
);
  tx_state_e  state_q;
  logic [7:0] shreg_q;
  logic [2:0] bit_idx_q;
  logic       stop_idx_q, len8_q, two_q, par_en_q, par_bit_q;
  logic       last_stop, accept;

  assign last_stop = (stop_idx_q == two_q);
  assign ready_o   = (state_q == ST_IDLE) ||
                     (state_q == ST_STOP && bit_tick_i && last_stop);
  assign accept    = valid_i && ready_o;
  assign load_o    = accept;
  assign de_o      = (state_q != ST_IDLE);
  assign active_o  = (state_q != ST_IDLE) && (state_q != ST_LEAD);

  always_comb begin
    case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shreg_q[0];
      ST_PAR:   txd_o = par_bit_q;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shreg_q    <= '0;
      bit_idx_q  <= '0;
      stop_idx_q <= 1'b0;
      len8_q     <= 1'b1;
      two_q      <= 1'b0;
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
    end else begin
      if (accept) begin
        shreg_q   <= data_i;
        len8_q    <= len8_i;
        two_q     <= two_stop_i;
        par_en_q  <= par_used(parity_i);
        par_bit_q <= par_value(parity_i, data_i, len8_i);
      end
      case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_LEAD;
        ST_LEAD:  if (bit_tick_i) state_q <= ST_START;
        ST_START: if (bit_tick_i) begin
          state_q   <= ST_DATA;
          bit_idx_q <= '0;
        end
        ST_DATA: if (bit_tick_i) begin
          shreg_q <= shreg_q >> 1;
          if (bit_idx_q == (len8_q ? 3'd7 : 3'd6)) begin
            state_q    <= par_en_q ? ST_PAR : ST_STOP;
            stop_idx_q <= 1'b0;
          end else begin
            bit_idx_q <= bit_idx_q + 3'd1;
          end
        end
        ST_PAR: if (bit_tick_i) begin
          state_q    <= ST_STOP;
          stop_idx_q <= 1'b0;
        end
        ST_STOP: if (bit_tick_i) begin
          if (last_stop) state_q <= accept ? ST_START : ST_IDLE;
          else           stop_idx_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (de_o && !ready_o)); // R2
  AST_LOW_NEEDS_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_o |-> de_o); // R7
endmodule

// File: rtl/uart_tx485_led.sv
module uart_tx485_led #(
  parameter int LED_MIN = 1200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic led_no
);
  localparam int CW = $clog2(LED_MIN + 1);

  logic [CW-1:0] cnt_q;

  assign led_no = !(active_i || (cnt_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (active_i)       cnt_q <= CW'(LED_MIN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  AST_LED_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_i) |-> !led_no); // R9
endmodule

// File: rtl/uart_tx485.sv
module uart_tx485 #(
  parameter int DIV_W   = 14,
  parameter int FRAC_W  = 3,
  parameter int LED_MIN = 1200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  output logic              ready_o,
  input  logic              len8_i,
  input  logic              two_stop_i,
  input  logic [2:0]        parity_i,
  input  logic              ovs10_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              txd_o,
  output logic              de_o,
  output logic              led_no
);
  logic bit_tick, load, active;

  uart_tx485_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
    .clk_i, .rst_ni,
    .load_i(load), .div_i, .frac_i, .ovs10_i,
    .bit_tick_o(bit_tick)
  );

  uart_tx485_frame u_frame (
    .clk_i, .rst_ni, .valid_i, .data_i, .len8_i, .two_stop_i, .parity_i,
    .bit_tick_i(bit_tick), .ready_o, .load_o(load),
    .txd_o, .de_o, .active_o(active)
  );

  uart_tx485_led #(.LED_MIN(LED_MIN)) u_led (
    .clk_i, .rst_ni, .active_i(active), .led_no
  );

  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (txd_o && ready_o)); // R1
  AST_LEAD_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_o) |-> txd_o); // R7
  AST_LED_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_o |-> !led_no); // R9
endmodule

// File: tb/uart_tx485_bench.sv
module uart_tx485_bench;
  localparam int DIV_W = 14, FRAC_W = 3, LED_MIN = 300;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, len8_i = 1'b1, two_stop_i = 1'b0, ovs10_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [2:0] parity_i = '0;
  logic [DIV_W-1:0] div_i = DIV_W'(4);
  logic [FRAC_W-1:0] frac_i = '0;
  logic ready_o, txd_o, de_o, led_no;

  uart_tx485 #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .LED_MIN(LED_MIN)) u_uart_tx485 (
    .clk_i, .rst_ni, .valid_i, .data_i, .ready_o, .len8_i, .two_stop_i,
    .parity_i, .ovs10_i, .div_i, .frac_i, .txd_o, .de_o, .led_no
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic [7:0] b; bit l8; bit s2; logic [2:0] par; bit o10; int dv; int fr; bit lead;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int de_rise_cyc = 0, de_fall_cyc = 0, de_fall_cnt = 0;
  int exp_end = 0;
  bit mon_busy = 0, done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // de edge tracking
  initial begin : de_track
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk_i);
      if (de_o && !prev) de_rise_cyc = cyc;
      if (!de_o && prev) begin de_fall_cyc = cyc; de_fall_cnt++; end
      prev = de_o;
    end
  end

  function automatic real bit_len(item_t it);
    return real'(it.o10 ? 10 : 16) * (real'(it.dv) + real'(it.fr) / 8.0);
  endfunction

  // monitor: decodes frames at bit centres and compares against queued items
  initial begin : monitor
    logic prev;
    int fall_snap;
    prev = 1'b1;
    fall_snap = 0;
    forever begin
      @(negedge clk_i);
      if (prev && !txd_o) begin
        item_t it;
        logic exp_bits [16];
        int nb, st;
        real bp;
        mon_busy = 1;
        st = cyc;
        if (q.size() == 0) begin
          chk(0, "R11 unexpected frame", 1, 0);
          it = '{b:8'h00, l8:1, s2:0, par:0, o10:0, dv:4, fr:0, lead:1};
        end else begin
          it = q.pop_front();
        end
        bp = bit_len(it);
        nb = 0;
        exp_bits[nb++] = 1'b0;
        for (int i = 0; i < (it.l8 ? 8 : 7); i++) exp_bits[nb++] = it.b[i];
        if (it.par >= 3'd1 && it.par <= 3'd4) begin
          logic ones;
          ones = it.l8 ? ^it.b : ^it.b[6:0];
          case (it.par)
            3'd1: exp_bits[nb++] = ~ones;
            3'd2: exp_bits[nb++] = ones;
            3'd3: exp_bits[nb++] = 1'b1;
            default: exp_bits[nb++] = 1'b0;
          endcase
        end
        exp_bits[nb++] = 1'b1;
        if (it.s2) exp_bits[nb++] = 1'b1;
        // R7 / R8: lead time or held enable
        if (it.lead) chk((st - de_rise_cyc) >= $rtoi(bp) - 1 && (st - de_rise_cyc) <= $rtoi(bp) + 1,
                         "R7 lead bit time", st - de_rise_cyc, $rtoi(bp));
        else chk(de_fall_cnt == fall_snap, "R8 enable held between frames", de_fall_cnt, fall_snap);
        chk(led_no == 1'b0, "R9 led low in frame", led_no, 0);
        for (int k = 0; k < nb; k++) begin
          int off;
          off = $rtoi(bp * (real'(k) + 0.5));
          while (cyc < st + off) @(negedge clk_i);
          chk(txd_o == exp_bits[k], (k == 0) ? "R3 start bit" :
              (k >= nb - (it.s2 ? 2 : 1)) ? "R5 stop bit" : "R3/R4/R6/R10 frame bit",
              txd_o, exp_bits[k]);
          if (k >= nb - (it.s2 ? 2 : 1)) chk(de_o == 1'b1, "R7 de through stop", de_o, 1);
        end
        exp_end = st + $rtoi(bp * real'(nb) + 0.5);
        fall_snap = de_fall_cnt;
        prev = 1'b1;
        mon_busy = 0;
      end else begin
        prev = txd_o;
      end
    end
  end

  // driver: offer a byte, push expectation on acceptance; valid stays high on return
  task automatic send(logic [7:0] b, bit l8, bit s2, logic [2:0] par, bit o10, int dv, int fr);
    item_t it;
    valid_i = 1; data_i = b; len8_i = l8; two_stop_i = s2; parity_i = par;
    ovs10_i = o10; div_i = DIV_W'(dv); frac_i = FRAC_W'(fr);
    forever begin
      if (ready_o) begin
        it = '{b:b, l8:l8, s2:s2, par:par, o10:o10, dv:dv, fr:fr, lead:!de_o};
        q.push_back(it);
        @(negedge clk_i);
        chk(ready_o == 1'b0, "R2 ready low after accept", ready_o, 0);
        break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic release_bus();
    valid_i = 0;
    data_i = ~data_i; len8_i = ~len8_i; two_stop_i = ~two_stop_i;
    parity_i = parity_i ^ 3'd3; ovs10_i = ~ovs10_i;
    div_i = div_i + DIV_W'(3); frac_i = ~frac_i;
  endtask

  task automatic wait_done();
    @(negedge clk_i);
    while (q.size() != 0 || mon_busy || de_o) @(negedge clk_i);
    chk(de_fall_cyc >= exp_end - 1 && de_fall_cyc <= exp_end + 1, "R7/R5 de falls at frame end",
        de_fall_cyc, exp_end);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin : main
    repeat (5) @(negedge clk_i);
    chk(txd_o == 1, "R1 reset txd", txd_o, 1);
    chk(de_o == 0, "R1 reset de", de_o, 0);
    chk(led_no == 1, "R1 reset led", led_no, 1);
    chk(ready_o == 1, "R1 reset ready", ready_o, 1);
    rst_ni = 1;
    repeat (200) @(negedge clk_i);
    chk(txd_o == 1 && de_o == 0, "R11 no valid stays idle", {txd_o, de_o}, 2);

    send(8'hA5, 1, 0, 3'd0, 0, 4, 0); release_bus(); wait_done();
    send(8'hFF, 0, 1, 3'd2, 1, 5, 3); release_bus(); wait_done();  // 7 bits, bit7 dropped
    send(8'h0B, 1, 0, 3'd1, 0, 3, 5); release_bus(); wait_done();  // odd
    send(8'h0B, 1, 1, 3'd2, 1, 6, 7); release_bus(); wait_done();  // even
    send(8'h5A, 0, 0, 3'd3, 1, 4, 1); release_bus(); wait_done();  // mark
    send(8'h81, 1, 1, 3'd4, 0, 2, 6); release_bus(); wait_done();  // space
    send(8'h33, 1, 0, 3'd6, 1, 3, 0); release_bus(); wait_done();  // reserved -> none

    // back-to-back chain with varying settings (R8)
    send(8'h12, 1, 0, 3'd2, 0, 3, 2);
    send(8'hE7, 0, 1, 3'd1, 1, 4, 0);
    send(8'h6C, 1, 0, 3'd0, 0, 3, 4);
    release_bus(); wait_done();

    // LED stretch after final frame (R9)
    while (cyc < de_fall_cyc + LED_MIN - 3) @(negedge clk_i);
    chk(led_no == 0, "R9 led stretched", led_no, 0);
    while (cyc < de_fall_cyc + LED_MIN + 3) @(negedge clk_i);
    chk(led_no == 1, "R9 led released", led_no, 1);
    chk(q.size() == 0, "R2 all bytes sent", q.size(), 0);
    finish_run();
  end
endmodule